// File: doc/BRIEF.md
# Burst Power-Up Switch Sequencer

This block is the control logic for a dual-band, burst-mode power-amplifier control loop. For each transmit slot it opens and closes the analog switches around the loop in a fixed order: the detector-sample switch, a feedback-short switch for each band, the pre-bias switch, the home-voltage switch and the loop-close switch. It also drives each band's output-driver enable and a clamp that holds that driver's output at ground.

A burst starts when the power-up input goes high. The block latches the band-select input at that moment and closes the sample, feedback and pre-bias switches for a fixed sampling interval. It then waits for a ramp-detect pulse from an external comparator. That pulse moves the control output from pre-bias to home voltage. After a fixed hold time it opens the feedback short and closes the loop. When power-up goes low, every switch opens and both driver outputs are clamped to ground on the next clock. Both intervals are clock-cycle parameters: `SAMPLE_CYC` and `HOLD_CYC`.

Top module: `pa_burst_seq`

## Requirements
- R1: While `pwr_en` is low, and after `rst`, the block is idle. `phase` is 0, all switch outputs are 0, `drv_on` is 00 and `drv_clamp` is 11. Ramp pulses and band changes have no effect while idle.
- R2: The first clock edge that samples `pwr_en` high while idle starts a burst and latches `band_hi`. A value of 0 selects the low band, which is bit 0 of `sw_fb`, `drv_on` and `drv_clamp`. A value of 1 selects the high band, which is bit 1.
- R3: Changes on `band_hi` during a burst do not change which band is active.
- R4: Throughout a burst, the band that is not selected has its driver off, its feedback switch open and its clamp on. The selected band has its driver on and its clamp off.
- R5: The first SAMPLE_CYC cycles of a burst are the sampling phase (`phase`=1). In this phase `sw_sample`, the selected `sw_fb` bit and `sw_prebias` are 1, and `sw_home` and `sw_loop` are 0.
- R6: After the sampling phase the block enters the ready phase (`phase`=2). `sw_sample` opens there. The selected `sw_fb` bit and `sw_prebias` stay closed.
- R7: A `ramp_hit` sampled in the ready phase moves the block on the next edge to the home phase (`phase`=3). There `sw_prebias` is 0, `sw_home` is 1 and the selected `sw_fb` bit stays 1.
- R8: The home phase lasts HOLD_CYC cycles. On the following edge the selected `sw_fb` bit opens and `sw_loop` closes in the same cycle (`phase`=4). `sw_home` stays 1, and the block holds this closed-loop phase until `pwr_en` falls.
- R9: A `ramp_hit` sampled during the sampling, home or closed-loop phase is ignored. Only the first pulse accepted in the ready phase has an effect.
- R10: A `pwr_en` low sampled in any burst phase returns the block to the idle configuration of R1 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Burst power-up level |
| band_hi | input | 1 | Band select (0 low band, 1 high band) |
| ramp_hit | input | 1 | Synchronized ramp-detect pulse |
| sw_sample | output | 1 | Detector-sample switch close |
| sw_fb | output | 2 | Per-band feedback-short switch close |
| sw_prebias | output | 1 | Pre-bias switch close |
| sw_home | output | 1 | Home-voltage switch close |
| sw_loop | output | 1 | Loop-close switch close |
| drv_on | output | 2 | Per-band output driver power-up |
| drv_clamp | output | 2 | Per-band output clamp to ground |
| phase | output | 3 | Current phase: 0 idle, 1 sampling, 2 ready, 3 home, 4 closed loop |

## Verification
All switch outputs are decoded from the phase register and the latched band, so a wrong internal state shows at the ports in the same cycle. A wrong timer count moves the edge of the sampling or home window by whole cycles. A missed or spurious ramp acceptance shows as `phase` and `sw_prebias`/`sw_home` going wrong on the edge that sampled the pulse. A band latch that follows the pin mid-burst flips `drv_on` and `drv_clamp` in the cycle after the pin toggles. The bench sweeps both bands, several ramp arrival times, early and late stray pulses, and a power-down in every phase. It compares the whole output vector on every cycle.

// File: rtl/pa_seq_pkg.sv
package pa_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SAMPLE = 3'd1,
        PH_READY  = 3'd2,
        PH_HOME   = 3'd3,
        PH_LOOP   = 3'd4
    } phase_t;

    // Shared (non band specific) switch closures for one phase
    typedef struct packed {
        logic sample;
        logic prebias;
        logic home;
        logic loop_cl;
        logic fb_sel;   // selected band feedback short closed
        logic active;   // selected driver powered, clamps released
    } sw_set_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic sw_set_t decode_phase(input phase_t ph);
        sw_set_t s;
        s = '0;
        case (ph)
            PH_SAMPLE: begin s.sample = 1'b1; s.prebias = 1'b1; s.fb_sel = 1'b1; s.active = 1'b1; end
            PH_READY:  begin s.prebias = 1'b1; s.fb_sel = 1'b1; s.active = 1'b1; end
            PH_HOME:   begin s.home = 1'b1; s.fb_sel = 1'b1; s.active = 1'b1; end
            PH_LOOP:   begin s.home = 1'b1; s.loop_cl = 1'b1; s.active = 1'b1; end
            default:   s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pa_seq_timer.sv
module pa_seq_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pa_seq_band.sv
module pa_seq_band (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic band_in,
    input  logic in_burst,
    output logic band_q
);
    always_ff @(posedge clk) begin
        if (rst)          band_q <= 1'b0;
        else if (capture) band_q <= band_in;
    end

    // R3: band held while the burst continues
    p_band_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (in_burst && !capture) |=> $stable(band_q));
endmodule

// File: rtl/pa_seq_fsm.sv
module pa_seq_fsm
    import pa_seq_pkg::*;
#(
    parameter int unsigned SAMPLE_CYC = 16,
    parameter int unsigned HOLD_CYC   = 250
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pwr_en,
    input  logic   ramp_hit,
    output phase_t state,
    output logic   start
);
    localparam int unsigned CW = $clog2(max2(SAMPLE_CYC, HOLD_CYC) + 1);
    localparam logic [CW-1:0] S_LD = CW'(SAMPLE_CYC - 1);
    localparam logic [CW-1:0] H_LD = CW'(HOLD_CYC - 1);

    phase_t        nxt;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_zero;

    pa_seq_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    assign start = (state == PH_IDLE) && pwr_en;

    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = S_LD;
        if (!pwr_en) begin
            nxt = PH_IDLE;
        end else begin
            case (state)
                PH_IDLE:   begin nxt = PH_SAMPLE; t_load = 1'b1; t_val = S_LD; end
                PH_SAMPLE: if (t_zero) nxt = PH_READY;
                PH_READY:  if (ramp_hit) begin nxt = PH_HOME; t_load = 1'b1; t_val = H_LD; end
                PH_HOME:   if (t_zero) nxt = PH_LOOP;
                PH_LOOP:   nxt = PH_LOOP;
                default:   nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PH_IDLE;
        else     state <= nxt;
    end

    p_sample_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SAMPLE && t_zero && pwr_en) |=> state == PH_READY);
    p_ramp_home_r7: assert property (@(posedge clk) disable iff (rst)
        (state == PH_READY && pwr_en && ramp_hit) |=> state == PH_HOME);
    p_ramp_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SAMPLE && pwr_en && !t_zero) |=> state == PH_SAMPLE);
    p_drop_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> state == PH_IDLE);
endmodule

// File: rtl/pa_burst_seq.sv
module pa_burst_seq
    import pa_seq_pkg::*;
#(
    parameter int unsigned SAMPLE_CYC = 16,
    parameter int unsigned HOLD_CYC   = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_en,
    input  logic       band_hi,
    input  logic       ramp_hit,
    output logic       sw_sample,
    output logic [1:0] sw_fb,
    output logic       sw_prebias,
    output logic       sw_home,
    output logic       sw_loop,
    output logic [1:0] drv_on,
    output logic [1:0] drv_clamp,
    output logic [2:0] phase
);
    localparam int NBAND = 2;

    phase_t  state;
    logic    start;
    logic    band_q;
    sw_set_t sw;

    pa_seq_fsm #(.SAMPLE_CYC(SAMPLE_CYC), .HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk(clk), .rst(rst), .pwr_en(pwr_en), .ramp_hit(ramp_hit),
        .state(state), .start(start)
    );

    pa_seq_band u_band (
        .clk(clk), .rst(rst), .capture(start), .band_in(band_hi),
        .in_burst(state != PH_IDLE), .band_q(band_q)
    );

    assign sw         = decode_phase(state);
    assign sw_sample  = sw.sample;
    assign sw_prebias = sw.prebias;
    assign sw_home    = sw.home;
    assign sw_loop    = sw.loop_cl;
    assign phase      = state;

    for (genvar b = 0; b < NBAND; b++) begin : g_band
        logic is_sel;
        assign is_sel       = (band_q == b[0]);
        assign sw_fb[b]     = sw.fb_sel && is_sel;
        assign drv_on[b]    = sw.active && is_sel;
        assign drv_clamp[b] = !(sw.active && is_sel);
    end

    p_idle_clamp_r1: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> (drv_clamp == 2'b11 && drv_on == 2'b00 && sw_fb == 2'b00));
    p_one_driver_r4: assert property (@(posedge clk) disable iff (rst)
        (phase != 3'd0) |-> ($onehot(drv_on) && $countones(drv_clamp) == 1));
    p_loop_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4 && $past(phase) != 3'd4) |-> ($past(phase) == 3'd3 && sw_fb == 2'b00));
endmodule

// File: tb/sim_pa_burst_seq.sv
module sim_pa_burst_seq;
    localparam int S = 5;
    localparam int H = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_en = 1'b0, band_hi = 1'b0, ramp_hit = 1'b0;
    logic       sw_sample, sw_prebias, sw_home, sw_loop;
    logic [1:0] sw_fb, drv_on, drv_clamp;
    logic [2:0] phase;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    pa_burst_seq #(.SAMPLE_CYC(S), .HOLD_CYC(H)) u0 (
        .clk(clk), .rst(rst), .pwr_en(pwr_en), .band_hi(band_hi), .ramp_hit(ramp_hit),
        .sw_sample(sw_sample), .sw_fb(sw_fb), .sw_prebias(sw_prebias), .sw_home(sw_home),
        .sw_loop(sw_loop), .drv_on(drv_on), .drv_clamp(drv_clamp), .phase(phase)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Expected port vector for a phase and band, from the requirements
    function automatic logic [13:0] expect_vec(input int ph, input int b);
        logic       smp, pb, hm, lp, fbs, act;
        logic [1:0] sel;
        smp = (ph == 1);
        pb  = (ph == 1 || ph == 2);
        hm  = (ph == 3 || ph == 4);
        lp  = (ph == 4);
        fbs = (ph >= 1 && ph <= 3);
        act = (ph != 0);
        sel = (b == 1) ? 2'b10 : 2'b01;
        return {smp, fbs ? sel : 2'b00, pb, hm, lp, act ? sel : 2'b00,
                act ? ~sel : 2'b11, 3'(ph)};
    endfunction

    function automatic logic [13:0] actual_vec();
        return {sw_sample, sw_fb, sw_prebias, sw_home, sw_loop, drv_on, drv_clamp, phase};
    endfunction

    function automatic string req_of(input int ph);
        case (ph)
            0: return "R1/R10";
            1: return "R5/R2/R4";
            2: return "R6/R3";
            3: return "R7/R9";
            default: return "R8/R9";
        endcase
    endfunction

    task automatic check_vec(input int ph, input int b, input string req);
        logic [13:0] e, a;
        e = expect_vec(ph, b);
        a = actual_vec();
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s: t=%0t actual=%b expected=%b", req, $time, a, e);
        end
    endtask

    // One burst: edge j=0 samples pwr_en high. Ramp valid at edge r,
    // stray pulses at e_early (<=S) and after home; power drops at edge f.
    task automatic run_burst(input int b, input int r, input int e_early, input int f);
        int total;
        total = r + H + 4;
        if (f + 2 > total) total = f + 2;
        pwr_en  = 1'b1;
        band_hi = b[0];
        for (int j = 0; j < total; j++) begin
            int ph;
            tick();
            if (j >= f)          ph = 0;
            else if (j < S)      ph = 1;
            else if (j < r)      ph = 2;
            else if (j < r + H)  ph = 3;
            else                 ph = 4;
            check_vec(ph, b, req_of(ph));
            // drive for edge j+1
            pwr_en   = (j + 1 < f);
            band_hi  = ~band_hi;                        // R3: toggling ignored
            ramp_hit = (j + 1 == r) || (j + 1 == e_early) ||
                       (j + 1 == r + 1) || (j + 1 == r + H + 1);  // R9 strays
        end
        ramp_hit = 1'b0;
        pwr_en   = 1'b0;
        // idle gap with stray inputs (R1)
        for (int g = 0; g < 3; g++) begin
            ramp_hit = g[0];
            band_hi  = ~band_hi;
            tick();
            check_vec(0, b, "R1");
        end
        ramp_hit = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        #1;
        check_vec(0, 0, "R1 reset");
        for (int b = 0; b < 2; b++) begin
            for (int dr = 1; dr <= 4; dr++) begin
                run_burst(b, S + dr, (dr % 2 == 1) ? S : 2, 1000);   // full burst
            end
            run_burst(b, S + 2, 1, 3);             // R10 drop in sampling
            run_burst(b, S + 3, 2, S + 1);         // R10 drop in ready
            run_burst(b, S + 1, 3, S + 2);         // R10 drop in home
            run_burst(b, S + 1, 4, S + 1 + H + 1); // R10 drop in loop
            run_burst(b, S + 1, S, S + 1);         // drop on the ramp edge
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule